// File: doc/BRIEF.md
# Keyed-Sequence Watchdog Timer

This block is a watchdog timer with a small register interface. A 32-bit up-counter advances on a slow reference tick. The tick can be divided by a power of two in a prescaler. When the counter passes its all-ones value, the block raises a reset request for one clock and restarts the count from the load value. Software keeps the system alive by writing the trigger register with a word that differs from the one already held there, which reloads the counter.

Starting and stopping the counter needs a two-word key sequence written to the key register. While the counter runs, the control and load registers are frozen. Every register write is posted. It takes effect a fixed number of clocks after the bus write, and a pending register shows software which posted writes have not yet landed.

The bus is a single-cycle write strobe with address and data. Reads are combinational from the address.

Top module: `kwdt_top`

## Requirements
- R1: After reset the counter is stopped, control reads 0, load and counter both read 0xFFFB0000, trigger reads 0, the pending register reads 0 and the reset request is low.
- R2: The register addresses are: control 0, load 1, counter 2 (read only), trigger 3, key 4, pending 5. The pending bits are: bit0 control, bit1 load, bit2 trigger, bit3 key. A write sampled at clock edge T sets its pending bit from edge T on. The new value takes effect at edge T+4, and the pending bit clears at that same edge.
- R3: Committing 0xAAAA and then 0x5555 to the key register stops the counter.
- R4: Committing 0xBBBB and then 0x4444 to the key register starts the counter.
- R5: A key word other than the expected second word abandons the sequence, and the run state stays as it was. An unexpected word is not taken as a new first word.
- R6: While the counter runs, committed writes to control and load are discarded.
- R7: A committed trigger word that differs from the stored trigger word reloads the counter from load. A trigger word equal to the stored word leaves the counter unchanged.
- R8: Control bit 5 enables the prescaler and bits [4:2] give the ratio r. With the prescaler enabled the counter advances once every 2^r ticks counted from the start. With the prescaler disabled it advances on every tick.
- R9: A step taken from 0xFFFFFFFF drives the reset request high for exactly the following clock and loads the counter from load.
- R10: When a trigger reload and a counter step fall on the same edge, the reload wins. The counter takes the load value, and no reset request is raised even if the counter held 0xFFFFFFFF.
- R11: While stopped, the counter ignores ticks.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| tick_i | input | 1 | Reference tick, one clock wide per tick |
| wr_en_i | input | 1 | Register write strobe |
| addr_i | input | 3 | Register address |
| wdata_i | input | 32 | Write data |
| rdata_o | output | 32 | Read data for addr_i |
| rst_req_o | output | 1 | One-clock reset request on overflow |

## Verification
Two functions can land on the same clock edge. One is a posted trigger write committing a changed word. The other is a reference tick that steps the counter. The bench provokes this by raising the tick exactly in the cycle of the fourth edge after the trigger write, once mid-count and once with the counter at all ones. It judges the result by requiring the counter to equal the load value with the reset request low. The same posted-write timing also drives the random phase, where the counter value and the count of reset pulses are compared against a bench model of the prescaler and the overflow.

// File: rtl/kwdt_pkg.sv
package kwdt_pkg;

    localparam int DATA_W  = 32;
    localparam int ADDR_W  = 3;
    localparam int N_POST  = 4;

    // posted slot indices (also pending-register bit positions)
    localparam int SL_CTRL = 0;
    localparam int SL_LOAD = 1;
    localparam int SL_TRIG = 2;
    localparam int SL_KEY  = 3;

    typedef enum logic [ADDR_W-1:0] {
        RA_CTRL  = 3'd0,
        RA_LOAD  = 3'd1,
        RA_COUNT = 3'd2,
        RA_TRIG  = 3'd3,
        RA_KEY   = 3'd4,
        RA_PEND  = 3'd5
    } reg_addr_e;

    localparam logic [DATA_W-1:0] KEY_STOP_A  = 32'h0000_AAAA;
    localparam logic [DATA_W-1:0] KEY_STOP_B  = 32'h0000_5555;
    localparam logic [DATA_W-1:0] KEY_START_A = 32'h0000_BBBB;
    localparam logic [DATA_W-1:0] KEY_START_B = 32'h0000_4444;

    localparam int PRE_EN_BIT = 5;
    localparam int RATIO_LSB  = 2;
    localparam logic [DATA_W-1:0] CTRL_MASK = 32'h0000_003C;

    typedef enum logic [1:0] {
        KS_IDLE   = 2'd0,
        KS_STOP1  = 2'd1,
        KS_START1 = 2'd2
    } key_state_e;

    // one-hot select of the posted slot addressed by a bus write
    function automatic logic [N_POST-1:0] post_sel(input logic [ADDR_W-1:0] a);
        logic [N_POST-1:0] s;
        s = '0;
        case (a)
            RA_CTRL: s[SL_CTRL] = 1'b1;
            RA_LOAD: s[SL_LOAD] = 1'b1;
            RA_TRIG: s[SL_TRIG] = 1'b1;
            RA_KEY:  s[SL_KEY]  = 1'b1;
            default: s = '0;
        endcase
        return s;
    endfunction

endpackage

// File: rtl/kwdt_post.sv
module kwdt_post #(
    parameter int DW  = 32,
    parameter int DLY = 4
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          wr_i,
    input  logic [DW-1:0] data_i,
    output logic          pend_o,
    output logic          commit_o,
    output logic [DW-1:0] data_o
);
    localparam int CW = (DLY > 1) ? $clog2(DLY) : 1;
    localparam logic [CW-1:0] START = CW'(DLY - 1);

    logic [CW-1:0] cnt_q;
    logic          pend_q;
    logic [DW-1:0] data_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt_q  <= '0;
            pend_q <= 1'b0;
            data_q <= '0;
        end else if (wr_i) begin
            cnt_q  <= START;
            pend_q <= 1'b1;
            data_q <= data_i;
        end else if (pend_q) begin
            if (cnt_q == '0) pend_q <= 1'b0;
            else             cnt_q  <= cnt_q - 1'b1;
        end
    end

    assign pend_o   = pend_q;
    assign commit_o = pend_q && (cnt_q == '0) && !wr_i;
    assign data_o   = data_q;

    // R2
    wr_sets_pend_chk: assert property (@(posedge clk) disable iff (rst)
        wr_i |=> pend_o);

    // R2
    commit_clears_chk: assert property (@(posedge clk) disable iff (rst)
        commit_o |=> !pend_o);

endmodule

// File: rtl/kwdt_keyseq.sv
module kwdt_keyseq
    import kwdt_pkg::*;
#(
    parameter int DW = 32
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          commit_i,
    input  logic [DW-1:0] word_i,
    output logic          run_o
);
    key_state_e st_q;
    logic       run_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q  <= KS_IDLE;
            run_q <= 1'b0;
        end else if (commit_i) begin
            case (st_q)
                KS_STOP1: begin
                    if (word_i == KEY_STOP_B) run_q <= 1'b0;
                    st_q <= KS_IDLE;
                end
                KS_START1: begin
                    if (word_i == KEY_START_B) run_q <= 1'b1;
                    st_q <= KS_IDLE;
                end
                default: begin
                    if (word_i == KEY_STOP_A)       st_q <= KS_STOP1;
                    else if (word_i == KEY_START_A) st_q <= KS_START1;
                    else                            st_q <= KS_IDLE;
                end
            endcase
        end
    end

    assign run_o = run_q;

    // R4
    start_needs_key_chk: assert property (@(posedge clk) disable iff (rst)
        $rose(run_o) |-> ($past(commit_i) && $past(word_i) == KEY_START_B));

    // R3
    stop_needs_key_chk: assert property (@(posedge clk) disable iff (rst)
        $fell(run_o) |-> ($past(commit_i) && $past(word_i) == KEY_STOP_B));

endmodule

// File: rtl/kwdt_prescale.sv
module kwdt_prescale #(
    parameter int RATIO_W = 3
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               run_i,
    input  logic               tick_i,
    input  logic               en_i,
    input  logic [RATIO_W-1:0] ratio_i,
    output logic               step_o
);
    localparam int PW = (1 << RATIO_W) - 1;

    logic [PW-1:0] pcnt_q;
    logic [PW-1:0] limit;

    assign limit  = ~({PW{1'b1}} << ratio_i);
    assign step_o = run_i && tick_i && (!en_i || (pcnt_q == limit));

    always_ff @(posedge clk) begin
        if (rst || !run_i)    pcnt_q <= '0;
        else if (tick_i) begin
            if (step_o)       pcnt_q <= '0;
            else              pcnt_q <= pcnt_q + 1'b1;
        end
    end

    // R11
    no_step_stopped_chk: assert property (@(posedge clk) disable iff (rst)
        !run_i |=> (pcnt_q == '0));

endmodule

// File: rtl/kwdt_core.sv
module kwdt_core #(
    parameter int               DW      = 32,
    parameter logic [DW-1:0]    CNT_RST = 32'hFFFB_0000
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          step_i,
    input  logic          reload_i,
    input  logic [DW-1:0] load_i,
    output logic [DW-1:0] count_o,
    output logic          ovf_o
);
    logic [DW-1:0] cnt_q;
    logic          ovf_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt_q <= CNT_RST;
            ovf_q <= 1'b0;
        end else begin
            ovf_q <= 1'b0;
            if (reload_i) begin
                cnt_q <= load_i;
            end else if (step_i) begin
                if (&cnt_q) begin
                    cnt_q <= load_i;
                    ovf_q <= 1'b1;
                end else begin
                    cnt_q <= cnt_q + 1'b1;
                end
            end
        end
    end

    assign count_o = cnt_q;
    assign ovf_o   = ovf_q;

    // R9
    ovf_from_all_ones_chk: assert property (@(posedge clk) disable iff (rst)
        ovf_o |-> ($past(count_o) == '1 && count_o == $past(load_i)));

    // R10
    reload_wins_chk: assert property (@(posedge clk) disable iff (rst)
        reload_i |=> (!ovf_o && count_o == $past(load_i)));

endmodule

// File: rtl/kwdt_top.sv
module kwdt_top
    import kwdt_pkg::*;
#(
    parameter int            POST_DLY = 4,
    parameter int            RATIO_W  = 3,
    parameter logic [31:0]   LOAD_RST = 32'hFFFB_0000
) (
    input  logic        clk,
    input  logic        rst,
    input  logic        tick_i,
    input  logic        wr_en_i,
    input  logic [2:0]  addr_i,
    input  logic [31:0] wdata_i,
    output logic [31:0] rdata_o,
    output logic        rst_req_o
);
    logic [N_POST-1:0]  sel;
    logic [N_POST-1:0]  pend;
    logic [N_POST-1:0]  commit;
    logic [DATA_W-1:0]  pdata [N_POST];

    logic [DATA_W-1:0]  ctrl_q, load_q, trig_q, key_q;
    logic [DATA_W-1:0]  count;
    logic               running;
    logic               trig_reload;
    logic               step;

    assign sel = wr_en_i ? post_sel(addr_i) : '0;

    for (genvar g = 0; g < N_POST; g++) begin : g_post
        kwdt_post #(.DW(DATA_W), .DLY(POST_DLY)) u_post (
            .clk      (clk),
            .rst      (rst),
            .wr_i     (sel[g]),
            .data_i   (wdata_i),
            .pend_o   (pend[g]),
            .commit_o (commit[g]),
            .data_o   (pdata[g])
        );
    end

    assign trig_reload = commit[SL_TRIG] && (pdata[SL_TRIG] != trig_q);

    always_ff @(posedge clk) begin
        if (rst) begin
            ctrl_q <= '0;
            load_q <= LOAD_RST;
            trig_q <= '0;
            key_q  <= '0;
        end else begin
            if (commit[SL_CTRL] && !running) ctrl_q <= pdata[SL_CTRL] & CTRL_MASK;
            if (commit[SL_LOAD] && !running) load_q <= pdata[SL_LOAD];
            if (commit[SL_TRIG])             trig_q <= pdata[SL_TRIG];
            if (commit[SL_KEY])              key_q  <= pdata[SL_KEY];
        end
    end

    kwdt_keyseq #(.DW(DATA_W)) u_keys (
        .clk      (clk),
        .rst      (rst),
        .commit_i (commit[SL_KEY]),
        .word_i   (pdata[SL_KEY]),
        .run_o    (running)
    );

    kwdt_prescale #(.RATIO_W(RATIO_W)) u_pre (
        .clk     (clk),
        .rst     (rst),
        .run_i   (running),
        .tick_i  (tick_i),
        .en_i    (ctrl_q[PRE_EN_BIT]),
        .ratio_i (ctrl_q[RATIO_LSB +: RATIO_W]),
        .step_o  (step)
    );

    kwdt_core #(.DW(DATA_W), .CNT_RST(LOAD_RST)) u_core (
        .clk      (clk),
        .rst      (rst),
        .step_i   (step),
        .reload_i (trig_reload),
        .load_i   (load_q),
        .count_o  (count),
        .ovf_o    (rst_req_o)
    );

    always_comb begin
        case (addr_i)
            RA_CTRL:  rdata_o = ctrl_q;
            RA_LOAD:  rdata_o = load_q;
            RA_COUNT: rdata_o = count;
            RA_TRIG:  rdata_o = trig_q;
            RA_KEY:   rdata_o = key_q;
            RA_PEND:  rdata_o = {{(DATA_W-N_POST){1'b0}}, pend};
            default:  rdata_o = '0;
        endcase
    end

    // R6
    ctrl_frozen_chk: assert property (@(posedge clk) disable iff (rst)
        (running && commit[SL_CTRL]) |=> $stable(ctrl_q));

    // R6
    load_frozen_chk: assert property (@(posedge clk) disable iff (rst)
        (running && commit[SL_LOAD]) |=> $stable(load_q));

    // R11
    hold_stopped_chk: assert property (@(posedge clk) disable iff (rst)
        (!running && !trig_reload) |=> $stable(count));

    // R7
    same_trig_keeps_chk: assert property (@(posedge clk) disable iff (rst)
        (commit[SL_TRIG] && !trig_reload && !step) |=> $stable(count));

endmodule

// File: tb/kwdt_top_bench.sv
module kwdt_top_bench;
    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        tick = 1'b0;
    logic        wr_en = 1'b0;
    logic [2:0]  addr = 3'd0;
    logic [31:0] wdata = '0;
    logic [31:0] rdata;
    logic        rst_req;

    int n_chk = 0;
    int n_bad = 0;
    bit finished = 0;

    // bench model of the counter
    logic [31:0] m_cnt, m_load;
    int          m_pc, m_div, m_ovf, seen_ovf;

    always #(CLK_PERIOD/2) clk = ~clk;

    kwdt_top u_kwdt_top (
        .clk(clk), .rst(rst), .tick_i(tick), .wr_en_i(wr_en),
        .addr_i(addr), .wdata_i(wdata), .rdata_o(rdata), .rst_req_o(rst_req)
    );

    function automatic int divisor(input logic [31:0] ctrl);
        return ctrl[5] ? (1 << ctrl[4:2]) : 1;
    endfunction

    task automatic chk(input string req, input logic [31:0] got, input logic [31:0] exp);
        n_chk++;
        if (got !== exp) begin
            n_bad++;
            $display("FAIL %s: got %h expected %h", req, got, exp);
        end
    endtask

    task automatic rd(input logic [2:0] a, output logic [31:0] v);
        addr = a;
        #1 v = rdata;
    endtask

    task automatic wr(input logic [2:0] a, input logic [31:0] d);
        wr_en = 1'b1; addr = a; wdata = d;
        @(posedge clk); @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic post_wr(input logic [2:0] a, input logic [31:0] d);
        wr(a, d);
        repeat (4) @(posedge clk);
        @(negedge clk);
    endtask

    task automatic tk();
        tick = 1'b1;
        @(posedge clk); @(negedge clk);
        tick = 1'b0;
        if (rst_req) seen_ovf++;
        m_pc++;
        if (m_pc == m_div) begin
            m_pc = 0;
            if (m_cnt == 32'hFFFF_FFFF) begin m_cnt = m_load; m_ovf++; end
            else m_cnt = m_cnt + 1;
        end
    endtask

    task automatic stop_wd();  post_wr(3'd4, 32'hAAAA); post_wr(3'd4, 32'h5555); endtask
    task automatic start_wd(); post_wr(3'd4, 32'hBBBB); post_wr(3'd4, 32'h4444); m_pc = 0; endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            n_bad++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        logic [31:0] v;
        logic [31:0] trig_val;
        int unsigned seed;
        seed = 32'd20240611;
        v = $urandom(seed);
        repeat (3) @(posedge clk);
        @(negedge clk); rst = 1'b0;

        // R1 reset state
        rd(3'd0, v); chk("R1 ctrl", v, 32'h0);
        rd(3'd1, v); chk("R1 load", v, 32'hFFFB_0000);
        rd(3'd2, v); chk("R1 count", v, 32'hFFFB_0000);
        rd(3'd3, v); chk("R1 trig", v, 32'h0);
        rd(3'd5, v); chk("R1 pend", v, 32'h0);
        chk("R1 rst_req", {31'b0, rst_req}, 32'h0);

        // R2 posted write timing on load
        wr(3'd1, 32'h0000_1000);
        rd(3'd5, v); chk("R2 pend set", v, 32'h2);
        repeat (3) @(posedge clk); @(negedge clk);
        rd(3'd5, v); chk("R2 pend held", v, 32'h2);
        rd(3'd1, v); chk("R2 load not yet", v, 32'hFFFB_0000);
        @(posedge clk); @(negedge clk);
        rd(3'd5, v); chk("R2 pend clear", v, 32'h0);
        rd(3'd1, v); chk("R2 load landed", v, 32'h0000_1000);
        wr(3'd0, 32'h0);
        rd(3'd5, v); chk("R2 ctrl pend bit0", v, 32'h1);
        repeat (4) @(posedge clk); @(negedge clk);
        wr(3'd4, 32'h0);
        rd(3'd5, v); chk("R2 key pend bit3", v, 32'h8);
        repeat (4) @(posedge clk); @(negedge clk);

        // R11 stopped counter ignores ticks
        m_load = 32'h1000; m_cnt = 32'hFFFB_0000; m_div = 1; m_pc = 0; m_ovf = 0; seen_ovf = 0;
        tick = 1'b1; repeat (3) @(posedge clk); @(negedge clk); tick = 1'b0;
        rd(3'd2, v); chk("R11 hold", v, 32'hFFFB_0000);

        // R7 changed trigger reloads
        post_wr(3'd3, 32'h1);
        rd(3'd2, v); chk("R7 reload", v, 32'h1000);

        // R4 start; first key alone does nothing
        post_wr(3'd4, 32'hBBBB);
        tick = 1'b1; @(posedge clk); @(negedge clk); tick = 1'b0;
        rd(3'd2, v); chk("R4 half key", v, 32'h1000);
        post_wr(3'd4, 32'h4444);
        m_cnt = 32'h1000; m_pc = 0;
        repeat (3) tk();
        rd(3'd2, v); chk("R4 running", v, 32'h1003);

        // R7 same trigger value leaves counter
        post_wr(3'd3, 32'h1);
        rd(3'd2, v); chk("R7 same word", v, 32'h1003);

        // R6 ctrl and load frozen while running
        post_wr(3'd0, 32'h3C);
        post_wr(3'd1, 32'h55);
        rd(3'd0, v); chk("R6 ctrl frozen", v, 32'h0);
        rd(3'd1, v); chk("R6 load frozen", v, 32'h1000);

        // R5 bad second word; stray AAAA after BBBB aborts
        post_wr(3'd4, 32'hAAAA); post_wr(3'd4, 32'h1234);
        tk(); rd(3'd2, v); chk("R5 still running", v, m_cnt);
        post_wr(3'd4, 32'hBBBB); post_wr(3'd4, 32'hAAAA); post_wr(3'd4, 32'h5555);
        tk(); rd(3'd2, v); chk("R5 abort no stop", v, m_cnt);

        // R3 stop
        stop_wd();
        tick = 1'b1; repeat (2) @(posedge clk); @(negedge clk); tick = 1'b0;
        rd(3'd2, v); chk("R3 stopped", v, m_cnt);

        // R8 prescaler enabled, ratio 2
        post_wr(3'd0, 32'h28);
        rd(3'd0, v); chk("R8 ctrl readback", v, 32'h28);
        start_wd(); m_div = 4;
        repeat (3) tk();
        rd(3'd2, v); chk("R8 div wait", v, 32'h1005);
        tk();
        rd(3'd2, v); chk("R8 div step", v, 32'h1006);
        stop_wd();
        post_wr(3'd0, 32'h08);
        start_wd(); m_div = 1;
        tk(); rd(3'd2, v); chk("R8 disabled every tick", v, 32'h1007);

        // R9 overflow
        stop_wd();
        post_wr(3'd0, 32'h0);
        post_wr(3'd1, 32'hFFFF_FFFE); m_load = 32'hFFFF_FFFE;
        post_wr(3'd3, 32'h2);
        start_wd();
        tk(); rd(3'd2, v); chk("R9 at all ones", v, 32'hFFFF_FFFF);
        chk("R9 no req yet", {31'b0, rst_req}, 32'h0);
        tk(); chk("R9 req high", {31'b0, rst_req}, 32'h1);
        rd(3'd2, v); chk("R9 reloaded", v, 32'hFFFF_FFFE);
        @(posedge clk); @(negedge clk);
        chk("R9 one cycle", {31'b0, rst_req}, 32'h0);

        // R10 trigger reload colliding with a step
        tk(); rd(3'd2, v); chk("R10 setup", v, 32'hFFFF_FFFF);
        wr(3'd3, 32'h3);
        repeat (3) @(posedge clk); @(negedge clk);
        tick = 1'b1; @(posedge clk); @(negedge clk); tick = 1'b0;
        rd(3'd2, v); chk("R10 reload wins at all ones", v, 32'hFFFF_FFFE);
        chk("R10 no req", {31'b0, rst_req}, 32'h0);
        tk(); tk();
        wr(3'd3, 32'h4);
        repeat (3) @(posedge clk); @(negedge clk);
        tick = 1'b1; @(posedge clk); @(negedge clk); tick = 1'b0;
        rd(3'd2, v); chk("R10 reload wins mid count", v, 32'hFFFF_FFFE);
        trig_val = 32'h4;

        // random phase: R8, R9, R7 under mixed settings
        for (int it = 0; it < 8; it++) begin
            logic [31:0] c;
            int nt;
            stop_wd();
            c = {26'b0, 1'($urandom % 2), 3'($urandom % 8), 2'b0};
            post_wr(3'd0, c);
            m_load = 32'hFFFF_FFFF - ($urandom % 6);
            post_wr(3'd1, m_load);
            trig_val = trig_val + 1;
            post_wr(3'd3, trig_val);
            m_cnt = m_load;
            rd(3'd2, v); chk("R7 random reload", v, m_cnt);
            start_wd(); m_div = divisor(c);
            m_ovf = 0; seen_ovf = 0;
            nt = 20 + ($urandom % 280);
            for (int k = 0; k < nt; k++) begin
                repeat ($urandom % 3) @(negedge clk);
                tk();
            end
            rd(3'd2, v); chk("R8 random count", v, m_cnt);
            chk("R9 random pulses", 32'(seen_ovf), 32'(m_ovf));
        end

        finished = 1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end
endmodule